// File: doc/BRIEF.md
# Context-Tagged Translation Buffer with Access Checks

This block is a fully associative translation buffer that turns a virtual address into a physical address. Each entry is keyed by a virtual page tag and an address-space context number, and maps one page of its own size. A lookup carries the virtual address, an address-space select, the access kind, the access size and the privilege of the requester. One cycle later the block returns the physical address, a hit flag and a one-hot fault cause.

Software owns the contents. It writes entries at indices of its choosing through a fill port, clears single entries by writing them invalid, and can drop every entry at once with an invalidate-all pulse. Two context registers hold the primary and secondary context numbers. The address-space select of each lookup chooses one of them, or the fixed kernel context zero.

Top module: `ctx_tlb`

## Requirements
- R1: After reset `res_valid`, `res_hit`, `res_pa` and `res_fault` are 0, and every entry is invalid, so the first lookup misses.
- R2: A lookup presented with `lk_valid`=1 is answered in the next cycle (`res_valid`=1). On a hit without fault, `res_hit`=1 and `res_pa` is the entry's frame number spliced with the page offset of `lk_va`.
- R3: `fill_psize` selects the page size: 0 = 8 KB, 1 = 64 KB, 2 = 512 KB, 3 = 4 MB (offset widths 13, 16, 19, 22 bits). The tag compare ignores, and the physical address takes from `lk_va`, every bit below the entry's own offset width.
- R4: A hit needs the entry's context to equal the selected context: `lk_space` 0 uses the primary register, 1 the secondary register, 2 context zero, and 3 acts as 0. `ctx_wr_en` with `ctx_wr_sel`=0 writes the primary register and 1 the secondary, visible from the next cycle.
- R5: With no matching entry, a fetch (`lk_kind`=2) sets fault bit 2 (instruction miss) and a load (0) or store (1) sets fault bit 3 (data miss). Kind 3 acts as a load.
- R6: A store that hits an entry with writable bit 0 sets fault bit 4 (write protection).
- R7: A load or store whose address has any of its low `lk_size` bits set sets fault bit 0 (alignment), where `lk_size` 0..3 means 1, 2, 4 or 8 bytes. Fetches are not checked for alignment.
- R8: A lookup with `lk_priv`=0 and `lk_space`=2 (kernel space) sets fault bit 1 (privileged action), whether or not an entry matches.
- R9: At most one fault bit is set, chosen in the order alignment, privileged action, miss, write protection. Any fault forces `res_hit`=0 and `res_pa`=0.
- R10: `fill_en` writes entry `fill_idx` with valid, tag, context, frame, size and writable fields. `fill_valid`=0 invalidates that entry. A fill in the same cycle as a lookup is not seen by that lookup, only by later ones.
- R11: `flush_all` clears every valid bit in one cycle. It wins over a fill in the same cycle.
- R12: When several entries match, the entry with the lowest index supplies the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W (44) | Virtual address |
| lk_space | input | 2 | Address-space select (0 primary, 1 secondary, 2 kernel) |
| lk_kind | input | 2 | Access kind (0 load, 1 store, 2 fetch) |
| lk_size | input | 2 | log2 of access bytes |
| lk_priv | input | 1 | Requester is privileged |
| fill_en | input | 1 | Write one entry |
| fill_idx | input | IDX_W (6) | Entry index to write |
| fill_valid | input | 1 | Valid bit written to the entry |
| fill_vpn | input | VA_W-13 (31) | Virtual page tag in 8 KB units |
| fill_ctx | input | CTX_W (13) | Context number of the entry |
| fill_ppn | input | PA_W-13 (28) | Physical frame in 8 KB units |
| fill_psize | input | 2 | Page size code |
| fill_writable | input | 1 | Stores allowed |
| flush_all | input | 1 | Invalidate every entry |
| ctx_wr_en | input | 1 | Write a context register |
| ctx_wr_sel | input | 1 | 0 primary, 1 secondary |
| ctx_wr_data | input | CTX_W (13) | Context value |
| res_valid | output | 1 | Result of last cycle's lookup |
| res_hit | output | 1 | Translation succeeded |
| res_pa | output | PA_W (41) | Physical address |
| res_fault | output | 5 | One-hot cause: 0 align, 1 privileged, 2 instr miss, 3 data miss, 4 write protect |

## Verification
A corrupted entry field shows on the very next lookup that touches it: a wrong tag or context turns a hit into a miss cause, a wrong size moves the boundary where addresses stop matching, and a wrong frame appears directly in `res_pa`. Lookups that straddle page boundaries of each size, alternate the three address spaces and force every fault cause against each neighbour in priority expose these one cycle after the request. Stale valid bits after an invalidate or flush show as a hit where a miss is due.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

   localparam int unsigned BASE_OFF = 13;
   localparam int unsigned MAX_EXTRA = 9;
   localparam int unsigned NFAULT = 5;

   localparam int unsigned F_ALIGN = 0;
   localparam int unsigned F_PRIV  = 1;
   localparam int unsigned F_IMISS = 2;
   localparam int unsigned F_DMISS = 3;
   localparam int unsigned F_WPROT = 4;

   typedef enum logic [1:0] {
      SP_PRIMARY   = 2'd0,
      SP_SECONDARY = 2'd1,
      SP_KERNEL    = 2'd2,
      SP_ALT       = 2'd3
   } space_e;

   typedef enum logic [1:0] {
      AK_LOAD  = 2'd0,
      AK_STORE = 2'd1,
      AK_FETCH = 2'd2,
      AK_ALT   = 2'd3
   } kind_e;

   // Bits of the 8 KB page number that a larger page leaves to the offset.
   function automatic logic [MAX_EXTRA-1:0] page_low_mask(input logic [1:0] psz);
      logic [MAX_EXTRA-1:0] m;
      case (psz)
         2'd0:    m = 9'h000;
         2'd1:    m = 9'h007;
         2'd2:    m = 9'h03F;
         default: m = 9'h1FF;
      endcase
      return m;
   endfunction

   // Address bits that must be zero for an access of 2**sz bytes.
   function automatic logic [2:0] size_low_mask(input logic [1:0] sz);
      logic [2:0] m;
      case (sz)
         2'd0:    m = 3'b000;
         2'd1:    m = 3'b001;
         2'd2:    m = 3'b011;
         default: m = 3'b111;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/ctx_tlb_entry.sv
module ctx_tlb_entry
   import ctx_tlb_pkg::*;
#(
   parameter int unsigned VPN_W = 31,
   parameter int unsigned PPN_W = 28,
   parameter int unsigned CTX_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic             wr_valid,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [CTX_W-1:0] wr_ctx,
   input  logic [PPN_W-1:0] wr_ppn,
   input  logic [1:0]       wr_psize,
   input  logic             wr_writable,
   input  logic [VPN_W-1:0] q_vpn,
   input  logic [CTX_W-1:0] q_ctx,
   output logic             match,
   output logic [PPN_W-1:0] ppn,
   output logic [1:0]       psize,
   output logic             writable
);

   logic             valid_q;
   logic [VPN_W-1:0] vpn_q;
   logic [CTX_W-1:0] ctx_q;
   logic [VPN_W-1:0] ignore;
   logic             tag_eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else if (flush) begin
         valid_q <= 1'b0;
      end else if (wr_en) begin
         valid_q <= wr_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !flush) begin
         vpn_q    <= wr_vpn;
         ctx_q    <= wr_ctx;
         ppn      <= wr_ppn;
         psize    <= wr_psize;
         writable <= wr_writable;
      end
   end

   always_comb begin
      ignore = VPN_W'(page_low_mask(psize));
      tag_eq = ((q_vpn ^ vpn_q) & ~ignore) == '0;
      match  = valid_q && tag_eq && (ctx_q == q_ctx);
   end

endmodule

// File: rtl/ctx_tlb_select.sv
module ctx_tlb_select #(
   parameter int unsigned N     = 64,
   parameter int unsigned PPN_W = 28
) (
   input  logic             match    [N],
   input  logic [PPN_W-1:0] ppn      [N],
   input  logic [1:0]       psize    [N],
   input  logic             writable [N],
   output logic             any,
   output logic [PPN_W-1:0] sel_ppn,
   output logic [1:0]       sel_psize,
   output logic             sel_writable
);

   // Walk from the top down so the lowest matching index is the last to win.
   always_comb begin
      any          = 1'b0;
      sel_ppn      = '0;
      sel_psize    = '0;
      sel_writable = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match[i]) begin
            any          = 1'b1;
            sel_ppn      = ppn[i];
            sel_psize    = psize[i];
            sel_writable = writable[i];
         end
      end
   end

endmodule

// File: rtl/ctx_tlb_fault.sv
module ctx_tlb_fault
   import ctx_tlb_pkg::*;
(
   input  logic [1:0]        kind,
   input  logic [1:0]        size,
   input  logic [2:0]        va_low,
   input  logic [1:0]        space,
   input  logic              priv,
   input  logic              hit_any,
   input  logic              writable,
   output logic [NFAULT-1:0] fault,
   output logic              ok
);

   logic is_fetch, is_store, misal, priv_bad, wprot;

   always_comb begin
      is_fetch = (kind == AK_FETCH);
      is_store = (kind == AK_STORE);
      misal    = !is_fetch && ((va_low & size_low_mask(size)) != 3'b000);
      priv_bad = !priv && (space == SP_KERNEL);
      wprot    = is_store && !writable;

      fault = '0;
      if (misal) begin
         fault[F_ALIGN] = 1'b1;
      end else if (priv_bad) begin
         fault[F_PRIV] = 1'b1;
      end else if (!hit_any) begin
         if (is_fetch) fault[F_IMISS] = 1'b1;
         else          fault[F_DMISS] = 1'b1;
      end else if (wprot) begin
         fault[F_WPROT] = 1'b1;
      end
      ok = (fault == '0);
   end

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
   import ctx_tlb_pkg::*;
#(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned VA_W    = 44,
   parameter int unsigned PA_W    = 41,
   parameter int unsigned CTX_W   = 13,
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned VPN_W  = VA_W - BASE_OFF,
   localparam int unsigned PPN_W  = PA_W - BASE_OFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [1:0]        lk_space,
   input  logic [1:0]        lk_kind,
   input  logic [1:0]        lk_size,
   input  logic              lk_priv,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [CTX_W-1:0]  fill_ctx,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [1:0]        fill_psize,
   input  logic              fill_writable,
   input  logic              flush_all,
   input  logic              ctx_wr_en,
   input  logic              ctx_wr_sel,
   input  logic [CTX_W-1:0]  ctx_wr_data,
   output logic              res_valid,
   output logic              res_hit,
   output logic [PA_W-1:0]   res_pa,
   output logic [NFAULT-1:0] res_fault
);

   initial begin
      if (ENTRIES < 2 || (1 << IDX_W) < ENTRIES)
         $fatal(1, "ctx_tlb: ENTRIES out of range");
      if (VPN_W < MAX_EXTRA || PPN_W < MAX_EXTRA)
         $fatal(1, "ctx_tlb: address widths too small for the largest page");
      if (CTX_W < 1)
         $fatal(1, "ctx_tlb: CTX_W must be positive");
   end

   // Context registers
   logic [CTX_W-1:0] ctx_pri_q, ctx_sec_q, q_ctx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctx_pri_q <= '0;
         ctx_sec_q <= '0;
      end else if (ctx_wr_en) begin
         if (ctx_wr_sel) ctx_sec_q <= ctx_wr_data;
         else            ctx_pri_q <= ctx_wr_data;
      end
   end

   always_comb begin
      case (lk_space)
         SP_SECONDARY: q_ctx = ctx_sec_q;
         SP_KERNEL:    q_ctx = '0;
         default:      q_ctx = ctx_pri_q;
      endcase
   end

   logic [VPN_W-1:0] q_vpn;
   assign q_vpn = lk_va[VA_W-1:BASE_OFF];

   // Entry array
   logic             e_match    [ENTRIES];
   logic [PPN_W-1:0] e_ppn      [ENTRIES];
   logic [1:0]       e_psize    [ENTRIES];
   logic             e_writable [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      logic sel_wr;
      assign sel_wr = fill_en && (fill_idx == IDX_W'(g));
      ctx_tlb_entry #(
         .VPN_W (VPN_W),
         .PPN_W (PPN_W),
         .CTX_W (CTX_W)
      ) u_entry (
         .clk         (clk),
         .rst_n       (rst_n),
         .flush       (flush_all),
         .wr_en       (sel_wr),
         .wr_valid    (fill_valid),
         .wr_vpn      (fill_vpn),
         .wr_ctx      (fill_ctx),
         .wr_ppn      (fill_ppn),
         .wr_psize    (fill_psize),
         .wr_writable (fill_writable),
         .q_vpn       (q_vpn),
         .q_ctx       (q_ctx),
         .match       (e_match[g]),
         .ppn         (e_ppn[g]),
         .psize       (e_psize[g]),
         .writable    (e_writable[g])
      );
   end

   // Winner selection
   logic             hit_any, hit_wr;
   logic [PPN_W-1:0] hit_ppn;
   logic [1:0]       hit_psize;

   ctx_tlb_select #(
      .N     (ENTRIES),
      .PPN_W (PPN_W)
   ) u_select (
      .match        (e_match),
      .ppn          (e_ppn),
      .psize        (e_psize),
      .writable     (e_writable),
      .any          (hit_any),
      .sel_ppn      (hit_ppn),
      .sel_psize    (hit_psize),
      .sel_writable (hit_wr)
   );

   // Physical address splice at the winner's page size
   logic [PPN_W-1:0] frame_mask, frame;
   logic [PA_W-1:0]  pa_next;

   always_comb begin
      frame_mask = PPN_W'(page_low_mask(hit_psize));
      frame      = (hit_ppn & ~frame_mask) | (PPN_W'(q_vpn) & frame_mask);
      pa_next    = {frame, lk_va[BASE_OFF-1:0]};
   end

   // Fault classification
   logic [NFAULT-1:0] fault_next;
   logic              access_ok;

   ctx_tlb_fault u_fault (
      .kind     (lk_kind),
      .size     (lk_size),
      .va_low   (lk_va[2:0]),
      .space    (lk_space),
      .priv     (lk_priv),
      .hit_any  (hit_any),
      .writable (hit_wr),
      .fault    (fault_next),
      .ok       (access_ok)
   );

   // Registered result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_pa    <= '0;
         res_fault <= '0;
      end else begin
         res_valid <= lk_valid;
         if (lk_valid) begin
            res_hit   <= access_ok;
            res_pa    <= access_ok ? pa_next : '0;
            res_fault <= fault_next;
         end else begin
            res_hit   <= 1'b0;
            res_pa    <= '0;
            res_fault <= '0;
         end
      end
   end

endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk
   import ctx_tlb_pkg::*;
#(
   parameter int unsigned VA_W = 44,
   parameter int unsigned PA_W = 41
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic [VA_W-1:0]   lk_va,
   input logic [1:0]        lk_space,
   input logic [1:0]        lk_kind,
   input logic [1:0]        lk_size,
   input logic              lk_priv,
   input logic              flush_all,
   input logic              res_valid,
   input logic              res_hit,
   input logic [PA_W-1:0]   res_pa,
   input logic [NFAULT-1:0] res_fault
);

   logic mem_access, misaligned;
   assign mem_access = (lk_kind != AK_FETCH);
   assign misaligned = mem_access && ((lk_va[2:0] & size_low_mask(lk_size)) != 3'b000);

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && lk_valid) |=> res_valid);

   assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !lk_valid) |=> (!res_valid && !res_hit && res_fault == '0));

   assert_imiss_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_fault[F_IMISS] |-> ($past(lk_kind) == AK_FETCH));

   assert_dmiss_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_fault[F_DMISS] |-> ($past(lk_kind) != AK_FETCH));

   assert_wprot_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_fault[F_WPROT] |-> ($past(lk_kind) == AK_STORE));

   assert_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && lk_valid && misaligned) |=> res_fault[F_ALIGN]);

   assert_priv_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && lk_valid && !misaligned && !lk_priv && lk_space == SP_KERNEL)
      |=> res_fault[F_PRIV]);

   assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(res_fault));

   assert_fault_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_fault != '0) |-> (!res_hit && res_pa == '0));

   assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && flush_all) |=> (lk_valid |=> !res_hit));

endmodule

bind ctx_tlb ctx_tlb_chk #(
   .VA_W (VA_W),
   .PA_W (PA_W)
) u_ctx_tlb_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_valid  (lk_valid),
   .lk_va     (lk_va),
   .lk_space  (lk_space),
   .lk_kind   (lk_kind),
   .lk_size   (lk_size),
   .lk_priv   (lk_priv),
   .flush_all (flush_all),
   .res_valid (res_valid),
   .res_hit   (res_hit),
   .res_pa    (res_pa),
   .res_fault (res_fault)
);

// File: tb/test_ctx_tlb.sv
`timescale 1ns/1ps
module test_ctx_tlb;

   localparam int VA_W  = 44;
   localparam int PA_W  = 41;
   localparam int CTX_W = 13;
   localparam int IDX_W = 6;
   localparam int VPN_W = VA_W - 13;
   localparam int PPN_W = PA_W - 13;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              lk_valid = 1'b0;
   logic [VA_W-1:0]   lk_va = '0;
   logic [1:0]        lk_space = '0, lk_kind = '0, lk_size = '0;
   logic              lk_priv = 1'b0;
   logic              fill_en = 1'b0;
   logic [IDX_W-1:0]  fill_idx = '0;
   logic              fill_valid = 1'b0;
   logic [VPN_W-1:0]  fill_vpn = '0;
   logic [CTX_W-1:0]  fill_ctx = '0;
   logic [PPN_W-1:0]  fill_ppn = '0;
   logic [1:0]        fill_psize = '0;
   logic              fill_writable = 1'b0;
   logic              flush_all = 1'b0;
   logic              ctx_wr_en = 1'b0;
   logic              ctx_wr_sel = 1'b0;
   logic [CTX_W-1:0]  ctx_wr_data = '0;
   logic              res_valid, res_hit;
   logic [PA_W-1:0]   res_pa;
   logic [4:0]        res_fault;

   always #2.5 clk = ~clk;

   ctx_tlb i_ctx_tlb (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_va(lk_va), .lk_space(lk_space), .lk_kind(lk_kind),
      .lk_size(lk_size), .lk_priv(lk_priv),
      .fill_en(fill_en), .fill_idx(fill_idx), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
      .fill_ctx(fill_ctx), .fill_ppn(fill_ppn), .fill_psize(fill_psize),
      .fill_writable(fill_writable), .flush_all(flush_all),
      .ctx_wr_en(ctx_wr_en), .ctx_wr_sel(ctx_wr_sel), .ctx_wr_data(ctx_wr_data),
      .res_valid(res_valid), .res_hit(res_hit), .res_pa(res_pa), .res_fault(res_fault)
   );

   int n_checks = 0;
   int n_fail   = 0;

   typedef struct packed {
      logic [43:0] va;
      logic [1:0]  sp;
      logic [1:0]  kd;
      logic [1:0]  sz;
      logic        pv;
      logic        hit;
      logic [40:0] pa;
      logic [4:0]  flt;
   } vec_t;

   localparam int NVEC = 18;
   localparam vec_t TBL [NVEC] = '{
      '{44'h000_0004_0010, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 41'h000_0024_6010, 5'h00}, // R2 8 KB
      '{44'h000_0004_0010, 2'd0, 2'd1, 2'd3, 1'b0, 1'b1, 41'h000_0024_6010, 5'h00}, // R6 writable store
      '{44'h000_0004_0011, 2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 41'h0,             5'h01}, // R7
      '{44'h000_00A0_ABCD, 2'd1, 2'd0, 2'd0, 1'b0, 1'b1, 41'h000_0008_ABCD, 5'h00}, // R3 R4 64 KB
      '{44'h000_00A0_ABCD, 2'd1, 2'd1, 2'd0, 1'b0, 1'b0, 41'h0,             5'h10}, // R6
      '{44'h000_00A0_ABCD, 2'd1, 2'd1, 2'd1, 1'b0, 1'b0, 41'h0,             5'h01}, // R9 align over wprot
      '{44'h000_00A0_ABCD, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 41'h0,             5'h08}, // R4 R5 wrong ctx
      '{44'h001_0023_4568, 2'd2, 2'd0, 2'd3, 1'b1, 1'b1, 41'h000_0223_4568, 5'h00}, // R3 R4 4 MB kernel
      '{44'h001_0023_4568, 2'd2, 2'd2, 2'd0, 1'b1, 1'b1, 41'h000_0223_4568, 5'h00}, // R2 fetch
      '{44'h001_0023_4568, 2'd2, 2'd0, 2'd3, 1'b0, 1'b0, 41'h0,             5'h02}, // R8
      '{44'h001_0023_4569, 2'd2, 2'd0, 2'd3, 1'b0, 1'b0, 41'h0,             5'h01}, // R9 align over priv
      '{44'h001_0023_4568, 2'd0, 2'd2, 2'd0, 1'b0, 1'b0, 41'h0,             5'h04}, // R5 instr miss
      '{44'h000_0807_FFF0, 2'd0, 2'd0, 2'd2, 1'b0, 1'b1, 41'h000_0047_FFF0, 5'h00}, // R3 512 KB top
      '{44'h000_0807_FFF0, 2'd0, 2'd2, 2'd0, 1'b0, 1'b1, 41'h000_0047_FFF0, 5'h00}, // R3
      '{44'h000_0808_0000, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 41'h0,             5'h08}, // R3 past page end
      '{44'h000_0807_FFF0, 2'd2, 2'd2, 2'd0, 1'b0, 1'b0, 41'h0,             5'h02}, // R9 priv over miss
      '{44'h000_0004_0011, 2'd0, 2'd2, 2'd0, 1'b0, 1'b1, 41'h000_0024_6011, 5'h00}, // R7 fetch exempt
      '{44'h000_0004_0010, 2'd3, 2'd0, 2'd0, 1'b0, 1'b1, 41'h000_0024_6010, 5'h00}  // R4 code 3
   };

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic check_res(input string req, input logic hit, input logic [40:0] pa,
                            input logic [4:0] flt);
      check({req, " valid"}, 64'(res_valid), 64'd1);
      check({req, " hit"},   64'(res_hit),   64'(hit));
      check({req, " pa"},    64'(res_pa),    64'(pa));
      check({req, " fault"}, 64'(res_fault), 64'(flt));
   endtask

   task automatic fill(input int idx, input logic v, input logic [VPN_W-1:0] vpn,
                       input logic [CTX_W-1:0] ctx, input logic [PPN_W-1:0] ppn,
                       input logic [1:0] psz, input logic wr);
      @(negedge clk);
      fill_en = 1'b1; fill_idx = IDX_W'(idx); fill_valid = v; fill_vpn = vpn;
      fill_ctx = ctx; fill_ppn = ppn; fill_psize = psz; fill_writable = wr;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic set_ctx(input logic sel, input logic [CTX_W-1:0] v);
      @(negedge clk);
      ctx_wr_en = 1'b1; ctx_wr_sel = sel; ctx_wr_data = v;
      @(negedge clk);
      ctx_wr_en = 1'b0;
   endtask

   task automatic drive_lk(input logic [43:0] va, input logic [1:0] sp, input logic [1:0] kd,
                           input logic [1:0] sz, input logic pv);
      lk_valid = 1'b1; lk_va = va; lk_space = sp; lk_kind = kd; lk_size = sz; lk_priv = pv;
   endtask

   task automatic lookup(input logic [43:0] va, input logic [1:0] sp, input logic [1:0] kd,
                         input logic [1:0] sz, input logic pv);
      @(negedge clk);
      drive_lk(va, sp, kd, sz, pv);
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 res_valid", 64'(res_valid), 64'd0);
      check("R1 res_hit",   64'(res_hit),   64'd0);
      check("R1 res_pa",    64'(res_pa),    64'd0);
      check("R1 res_fault", 64'(res_fault), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      lookup(44'h000_0004_0010, 2'd2, 2'd0, 2'd0, 1'b1);
      check_res("R1 empty after reset", 1'b0, 41'h0, 5'h08);

      // Contexts and entries for the table
      set_ctx(1'b0, 13'd5);
      set_ctx(1'b1, 13'd9);
      fill(0, 1'b1, 31'h20,    13'd5, 28'h123,  2'd0, 1'b1);
      fill(1, 1'b1, 31'h500,   13'd9, 28'h40,   2'd1, 1'b0);
      fill(2, 1'b1, 31'h80000, 13'd0, 28'h1000, 2'd3, 1'b1);
      fill(3, 1'b1, 31'h4000,  13'd5, 28'h200,  2'd2, 1'b1);

      for (int i = 0; i < NVEC; i++) begin
         lookup(TBL[i].va, TBL[i].sp, TBL[i].kd, TBL[i].sz, TBL[i].pv);
         check_res($sformatf("R2 R3 R4 R5 R6 R7 R8 R9 vector %0d", i),
                   TBL[i].hit, TBL[i].pa, TBL[i].flt);
      end

      // R10: fill in the same cycle as a lookup is not seen by it
      @(negedge clk);
      fill_en = 1'b1; fill_idx = 6'd10; fill_valid = 1'b1; fill_vpn = 31'h180;
      fill_ctx = 13'd5; fill_ppn = 28'h77; fill_psize = 2'd0; fill_writable = 1'b1;
      drive_lk(44'h000_0030_0000, 2'd0, 2'd0, 2'd0, 1'b0);
      @(negedge clk);
      fill_en = 1'b0; lk_valid = 1'b0;
      check_res("R10 same-cycle fill unseen", 1'b0, 41'h0, 5'h08);
      lookup(44'h000_0030_0000, 2'd0, 2'd0, 2'd0, 1'b0);
      check_res("R10 fill seen later", 1'b1, 41'h0EE000, 5'h00);

      // R12: lowest index wins among duplicates
      fill(30, 1'b1, 31'h280, 13'd5, 28'h11, 2'd0, 1'b1);
      fill(20, 1'b1, 31'h280, 13'd5, 28'h22, 2'd0, 1'b1);
      lookup(44'h000_0050_0000, 2'd0, 2'd0, 2'd0, 1'b0);
      check_res("R12 lowest index", 1'b1, 41'h044000, 5'h00);

      // R10: invalidate a single entry
      fill(20, 1'b0, 31'h280, 13'd5, 28'h22, 2'd0, 1'b1);
      lookup(44'h000_0050_0000, 2'd0, 2'd0, 2'd0, 1'b0);
      check_res("R10 invalidate one", 1'b1, 41'h022000, 5'h00);

      // R4: rewrite the primary context
      set_ctx(1'b0, 13'd9);
      lookup(44'h000_00A0_ABCD, 2'd0, 2'd0, 2'd0, 1'b0);
      check_res("R4 new primary ctx", 1'b1, 41'h08ABCD, 5'h00);
      lookup(44'h000_0004_0010, 2'd0, 2'd0, 2'd0, 1'b0);
      check_res("R4 old ctx misses", 1'b0, 41'h0, 5'h08);

      // R11: flush wins over a fill in the same cycle
      @(negedge clk);
      flush_all = 1'b1;
      fill_en = 1'b1; fill_idx = 6'd5; fill_valid = 1'b1; fill_vpn = 31'h20;
      fill_ctx = 13'd9; fill_ppn = 28'h5; fill_psize = 2'd0; fill_writable = 1'b1;
      @(negedge clk);
      flush_all = 1'b0; fill_en = 1'b0;
      lookup(44'h001_0023_4568, 2'd2, 2'd0, 2'd3, 1'b1);
      check_res("R11 flush clears", 1'b0, 41'h0, 5'h08);
      lookup(44'h000_0004_0010, 2'd0, 2'd0, 2'd0, 1'b0);
      check_res("R11 flush beats fill", 1'b0, 41'h0, 5'h08);
      lookup(44'h000_0050_0000, 2'd0, 2'd0, 2'd0, 1'b0);
      check_res("R11 entry 30 gone", 1'b0, 41'h0, 5'h08);

      @(negedge clk);
      check("R2 idle result", 64'(res_valid), 64'd0);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule